// File: doc/BRIEF.md
# Streaming Priority Register Access Gate

This block holds the streaming-execution priority control register and rules on every system-register read or write that decodes to it. The core presents the 16-bit system encoding of the access, its direction, the current exception level, the feature-present flags and the trap-control bits of the higher levels. In the same cycle the block returns exactly one outcome: carry out the access, report the instruction as undefined, or trap to level 2 or level 3 with syndrome class 0x18.

The outcome comes from an ordered chain of tests that depends on the level. At level 1 a debug-driven undefined override comes first. The hypervisor's fine-grained per-direction trap comes next, and the monitor's enable trap comes last. At level 2 the fine-grained trap is skipped. At level 3 only the monitor enable is tested. The stored value is a 4-bit priority field, and the other 60 bits always read as zero. When the platform reports that streaming priority is unsupported, the whole register reads as zero and ignores writes. A write changes the register on the next clock edge, and only when the outcome is ACCESS.

Top module: `prio_gate`

## Requirements
- R1: An access is recognised (`hit`=1) only when `reqValid`=1 and `reqEnc`={op0,op1,CRn,CRm,op2} equals 16'hC094 (11,000,0001,0010,100). Otherwise `outcome` is 4'b0000 and `rdData` is 0.
- R2: For a recognised access, if `featStream`=0 or `curEl`=0, the outcome is UNDEF.
- R3: At `curEl`=1, if `hasEl3`=1, `dbgUndefPrio`=1 and `esmEn`=0, the outcome is UNDEF. This test comes before the fine-grained trap.
- R4: At `curEl`=1, when R3 does not apply, if `el2Enabled`=1, `featFgt`=1 and (`hasEl3`=0 or `fgtEnEl3`=1), and the direction's trap bit is 0 (`nTrapRd` for reads, `nTrapWr` for writes), the outcome is TRAP_EL2.
- R5: At `curEl`=1 or 2, when no earlier test applies, if `hasEl3`=1 and `esmEn`=0, the outcome is TRAP_EL3, or UNDEF when `dbgUndef`=1. Otherwise the outcome is ACCESS.
- R6: At `curEl`=2, the fine-grained inputs (`featFgt`, `fgtEnEl3`, `nTrapRd`, `nTrapWr`, `el2Enabled`) have no effect. The chain is the same as at level 1, with the R4 step removed.
- R7: At `curEl`=3, if `esmEn`=0 the outcome is TRAP_EL3. Otherwise it is ACCESS.
- R8: A write with outcome ACCESS and `prioSupported`=1 stores `wrData[3:0]` on the next clock edge. A read with outcome ACCESS returns the stored field zero-extended, and bits [63:4] are always 0.
- R9: A write whose outcome is not ACCESS leaves the stored priority unchanged.
- R10: With `prioSupported`=0, reads return 0 and writes do not change the stored field.
- R11: `outcome` is one-hot while `hit`=1, with bit 0 ACCESS, bit 1 UNDEF, bit 2 TRAP_EL2 and bit 3 TRAP_EL3. `syndClass` is 8'h18 for the two trap outcomes and 0 otherwise.
- R12: After reset the stored priority is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Access request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqEnc | input | 16 | System encoding {op0,op1,CRn,CRm,op2} |
| curEl | input | 2 | Current exception level |
| featStream | input | 1 | Streaming extension implemented |
| featFgt | input | 1 | Fine-grained traps implemented |
| hasEl3 | input | 1 | Level 3 implemented |
| el2Enabled | input | 1 | Level 2 enabled in current state |
| fgtEnEl3 | input | 1 | Level-3 enable for fine-grained traps |
| nTrapRd | input | 1 | Fine-grained read trap control, 0 = trap |
| nTrapWr | input | 1 | Fine-grained write trap control, 0 = trap |
| esmEn | input | 1 | Monitor enable for streaming state, 0 = trap |
| dbgUndefPrio | input | 1 | Debug condition that forces undefined ahead of the traps |
| dbgUndef | input | 1 | Debug condition that turns the level-3 trap into undefined |
| prioSupported | input | 1 | Streaming priority supported |
| wrData | input | 64 | Write data |
| hit | output | 1 | Encoding matched on a valid request |
| outcome | output | 4 | One-hot outcome |
| syndClass | output | 8 | Syndrome class for traps |
| rdData | output | 64 | Read data |

## Verification
On every cycle the assertions check the one-hot outcome and its syndrome class. They also check that an unrecognised access produces no outcome, that level 0 and level 3 resolve as required, and that reads are zero when priority is unsupported. For the stored field, they check that it holds still unless a permitted write occurs and that it takes the written nibble after one. The ordering of the level-1 chain, the per-direction choice of the fine-grained trap bit, and the skipping of that trap at level 2 only show up in the bench's scenarios. Those scenarios compare every vector against an independent model of the chain.

// File: rtl/prio_gate_pkg.sv
package prio_gate_pkg;
  localparam int ENC_W   = 16;
  localparam int CLASS_W = 8;
  localparam logic [ENC_W-1:0]   REG_ENC    = 16'hC094;
  localparam logic [CLASS_W-1:0] TRAP_CLASS = 8'h18;

  typedef enum logic [3:0] {
    OUT_NONE   = 4'b0000,
    OUT_ACCESS = 4'b0001,
    OUT_UNDEF  = 4'b0010,
    OUT_TRAP2  = 4'b0100,
    OUT_TRAP3  = 4'b1000
  } outcome_e;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } strobe_t;
endpackage

// File: rtl/prio_gate_ctrl.sv
module prio_gate_ctrl
  import prio_gate_pkg::*;
(
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [ENC_W-1:0]   reqEnc,
  input  logic [1:0]         curEl,
  input  logic               featStream,
  input  logic               featFgt,
  input  logic               hasEl3,
  input  logic               el2Enabled,
  input  logic               fgtEnEl3,
  input  logic               nTrapRd,
  input  logic               nTrapWr,
  input  logic               esmEn,
  input  logic               dbgUndefPrio,
  input  logic               dbgUndef,
  input  logic               prioSupported,
  output logic               hit,
  output outcome_e           outcome,
  output logic [CLASS_W-1:0] syndClass,
  output strobe_t            strobe
);
  logic     fgtArmed, fgtBit, monTrap, prioUndef;
  outcome_e chainRes;

  assign hit       = reqValid && (reqEnc == REG_ENC);
  assign monTrap   = hasEl3 && !esmEn;
  assign prioUndef = monTrap && dbgUndefPrio;
  assign fgtArmed  = el2Enabled && featFgt && (!hasEl3 || fgtEnEl3);
  assign fgtBit    = reqWrite ? nTrapWr : nTrapRd;

  always_comb begin
    chainRes = OUT_ACCESS;
    if (!featStream) begin
      chainRes = OUT_UNDEF;
    end else begin
      unique case (curEl)
        2'd0: chainRes = OUT_UNDEF;
        2'd1: begin
          if (prioUndef)               chainRes = OUT_UNDEF;
          else if (fgtArmed && !fgtBit) chainRes = OUT_TRAP2;
          else if (monTrap)             chainRes = dbgUndef ? OUT_UNDEF : OUT_TRAP3;
          else                          chainRes = OUT_ACCESS;
        end
        2'd2: begin
          if (prioUndef)   chainRes = OUT_UNDEF;
          else if (monTrap) chainRes = dbgUndef ? OUT_UNDEF : OUT_TRAP3;
          else              chainRes = OUT_ACCESS;
        end
        default: chainRes = esmEn ? OUT_ACCESS : OUT_TRAP3;
      endcase
    end
  end

  assign outcome   = hit ? chainRes : OUT_NONE;
  assign syndClass = (outcome == OUT_TRAP2 || outcome == OUT_TRAP3) ? TRAP_CLASS : '0;

  always_comb begin
    strobe.wrEn = hit && reqWrite  && (chainRes == OUT_ACCESS) && prioSupported;
    strobe.rdEn = hit && !reqWrite && (chainRes == OUT_ACCESS) && prioSupported;
  end
endmodule

// File: rtl/prio_gate_dpath.sv
module prio_gate_dpath
  import prio_gate_pkg::*;
#(
  parameter int REG_W  = 64,
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [REG_W-1:0]  wrData,
  output logic [PRIO_W-1:0] prioQ,
  output logic [REG_W-1:0]  rdData
);
  localparam int PAD_W = REG_W - PRIO_W;
  logic unusedWrHi;

  assign unusedWrHi = ^wrData[REG_W-1:PRIO_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            prioQ <= '0;
    else if (strobe.wrEn) prioQ <= wrData[PRIO_W-1:0];
  end

  assign rdData = strobe.rdEn ? {{PAD_W{1'b0}}, prioQ} : '0;
endmodule

// File: rtl/prio_gate.sv
module prio_gate
  import prio_gate_pkg::*;
#(
  parameter int REG_W  = 64,
  parameter int PRIO_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [ENC_W-1:0]   reqEnc,
  input  logic [1:0]         curEl,
  input  logic               featStream,
  input  logic               featFgt,
  input  logic               hasEl3,
  input  logic               el2Enabled,
  input  logic               fgtEnEl3,
  input  logic               nTrapRd,
  input  logic               nTrapWr,
  input  logic               esmEn,
  input  logic               dbgUndefPrio,
  input  logic               dbgUndef,
  input  logic               prioSupported,
  input  logic [REG_W-1:0]   wrData,
  output logic               hit,
  output logic [3:0]         outcome,
  output logic [CLASS_W-1:0] syndClass,
  output logic [REG_W-1:0]   rdData
);
  strobe_t           strobe;
  outcome_e          outcomeE;
  logic [PRIO_W-1:0] prioQ;

  prio_gate_ctrl u_ctrl (
    .reqValid, .reqWrite, .reqEnc, .curEl, .featStream, .featFgt, .hasEl3,
    .el2Enabled, .fgtEnEl3, .nTrapRd, .nTrapWr, .esmEn, .dbgUndefPrio,
    .dbgUndef, .prioSupported, .hit, .outcome(outcomeE), .syndClass, .strobe
  );

  prio_gate_dpath #(.REG_W(REG_W), .PRIO_W(PRIO_W)) u_dp (
    .clk, .rstN, .strobe, .wrData, .prioQ, .rdData
  );

  assign outcome = outcomeE;
endmodule

// File: rtl/prio_gate_chk.sv
module prio_gate_chk #(
  parameter int REG_W  = 64,
  parameter int PRIO_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              hit,
  input logic              reqWrite,
  input logic [1:0]        curEl,
  input logic              esmEn,
  input logic              featStream,
  input logic              prioSupported,
  input logic [3:0]        outcome,
  input logic [7:0]        syndClass,
  input logic [REG_W-1:0]  rdData,
  input logic [REG_W-1:0]  wrData,
  input logic [PRIO_W-1:0] prioQ
);
  logic permWrite;
  assign permWrite = hit && reqWrite && outcome[0] && prioSupported;

  p_nohit_r1: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (outcome == 4'b0000 && rdData == '0));
  p_el0_undef_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hit && curEl == 2'd0) |-> outcome == 4'b0010);
  p_el3_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hit && featStream && curEl == 2'd3) |-> outcome == (esmEn ? 4'b0001 : 4'b1000));
  p_store_r8: assert property (@(posedge clk) disable iff (!rstN)
    permWrite |=> prioQ == $past(wrData[PRIO_W-1:0]));
  p_rd_hi_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdData[REG_W-1:PRIO_W] == '0);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !permWrite |=> $stable(prioQ));
  p_unsup_rd_r10: assert property (@(posedge clk) disable iff (!rstN)
    !prioSupported |-> rdData == '0);
  p_onehot_r11: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> $countones(outcome) == 1);
  p_class_r11: assert property (@(posedge clk) disable iff (!rstN)
    syndClass == ((outcome[2] || outcome[3]) ? 8'h18 : 8'h00));
endmodule

bind prio_gate prio_gate_chk #(.REG_W(REG_W), .PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/sim_prio_gate.sv
module sim_prio_gate;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] ENC = 16'hC094;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0;
  logic [15:0] reqEnc = '0;
  logic [1:0]  curEl = '0;
  logic featStream = 0, featFgt = 0, hasEl3 = 0, el2Enabled = 0, fgtEnEl3 = 0;
  logic nTrapRd = 0, nTrapWr = 0, esmEn = 0, dbgUndefPrio = 0, dbgUndef = 0;
  logic prioSupported = 0;
  logic [63:0] wrData = '0;
  logic hit;
  logic [3:0] outcome;
  logic [7:0] syndClass;
  logic [63:0] rdData;

  int nChecks = 0, nFails = 0;
  logic [3:0] modelPrio = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_gate u0 (.*);

  function automatic logic [3:0] expOutcome(output string tag);
    logic match = reqValid && reqEnc == ENC;
    logic mon = hasEl3 && !esmEn;
    tag = "R1";
    if (!match) return 4'b0000;
    tag = "R2";
    if (!featStream || curEl == 2'd0) return 4'b0010;
    if (curEl == 2'd3) begin tag = "R7"; return esmEn ? 4'b0001 : 4'b1000; end
    tag = "R3";
    if (mon && dbgUndefPrio) return 4'b0010;
    if (curEl == 2'd1 && el2Enabled && featFgt && (!hasEl3 || fgtEnEl3) &&
        !(reqWrite ? nTrapWr : nTrapRd)) begin tag = "R4"; return 4'b0100; end
    tag = (curEl == 2'd2) ? "R6" : "R5";
    if (mon) return dbgUndef ? 4'b0010 : 4'b1000;
    return 4'b0001;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at negedge, compare before next posedge, then advance model.
  task automatic applyVec();
    string tag;
    logic [3:0] eo;
    logic [63:0] er;
    @(negedge clk);
    #1;
    eo = expOutcome(tag);
    check(tag, {60'd0, outcome}, {60'd0, eo});
    check("R11", {56'd0, syndClass}, (eo[2] | eo[3]) ? 64'h18 : 64'h0);
    er = (eo == 4'b0001 && !reqWrite && prioSupported) ? {60'd0, modelPrio} : 64'd0;
    check(prioSupported ? "R8" : "R10", rdData, er);
    if (eo == 4'b0001 && reqWrite && prioSupported) modelPrio = wrData[3:0];
  endtask

  task automatic setBase(logic [1:0] el, logic wr, logic [63:0] d);
    reqValid = 1; reqEnc = ENC; reqWrite = wr; curEl = el; wrData = d;
    featStream = 1; featFgt = 0; hasEl3 = 0; el2Enabled = 0; fgtEnEl3 = 0;
    nTrapRd = 1; nTrapWr = 1; esmEn = 1; dbgUndefPrio = 0; dbgUndef = 0;
    prioSupported = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    // R12: reset value readable
    setBase(2'd1, 0, '0);
    applyVec();
    check("R12", rdData, 64'd0);
    // R8: write full 64-bit word, upper bits dropped
    setBase(2'd1, 1, 64'hFFFF_FFFF_FFFF_FFFA); applyVec();
    setBase(2'd1, 0, '0); applyVec();
    check("R8", rdData, 64'h000A);
    // R3 ordering: priority-undef wins over fgt trap
    setBase(2'd1, 1, 64'h3); hasEl3 = 1; esmEn = 0; dbgUndefPrio = 1;
    el2Enabled = 1; featFgt = 1; fgtEnEl3 = 1; nTrapWr = 0; applyVec();
    // R4: read uses read bit only
    setBase(2'd1, 0, '0); el2Enabled = 1; featFgt = 1; nTrapRd = 0; nTrapWr = 1; applyVec();
    setBase(2'd1, 0, '0); el2Enabled = 1; featFgt = 1; nTrapRd = 1; nTrapWr = 0; applyVec();
    // R9: trapped write leaves value
    setBase(2'd1, 1, 64'h5); el2Enabled = 1; featFgt = 1; nTrapWr = 0; applyVec();
    setBase(2'd1, 0, '0); applyVec();
    check("R9", rdData, 64'h000A);
    // R6: level 2 ignores fgt controls
    setBase(2'd2, 1, 64'h7); el2Enabled = 1; featFgt = 1; nTrapWr = 0; nTrapRd = 0; applyVec();
    setBase(2'd2, 0, '0); applyVec();
    check("R6", rdData, 64'h0007);
    // R5: monitor trap, and debug override to undef
    setBase(2'd2, 0, '0); hasEl3 = 1; esmEn = 0; applyVec();
    setBase(2'd1, 0, '0); hasEl3 = 1; esmEn = 0; dbgUndef = 1; applyVec();
    // R10: unsupported ignores write
    setBase(2'd3, 1, 64'h2); prioSupported = 0; applyVec();
    setBase(2'd3, 0, '0); applyVec();
    check("R10", rdData, 64'h0007);
    // R1: wrong encoding, write ignored
    setBase(2'd3, 1, 64'h1); reqEnc = ENC ^ 16'h0001; applyVec();
    setBase(2'd3, 0, '0); applyVec();
    check("R1", rdData, 64'h0007);

    for (int i = 0; i < 3000; i++) begin
      reqValid = ($urandom % 8) != 0;
      reqEnc = ($urandom % 4 != 0) ? ENC : 16'($urandom);
      reqWrite = $urandom % 2; curEl = 2'($urandom);
      featStream = ($urandom % 10) != 0; featFgt = $urandom % 2;
      hasEl3 = $urandom % 2; el2Enabled = $urandom % 2; fgtEnEl3 = $urandom % 2;
      nTrapRd = $urandom % 2; nTrapWr = $urandom % 2;
      esmEn = ($urandom % 3) != 0; dbgUndefPrio = ($urandom % 4) == 0;
      dbgUndef = ($urandom % 3) == 0; prioSupported = ($urandom % 6) != 0;
      wrData = {$urandom, $urandom};
      applyVec();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule